// File: doc/BRIEF.md
# JTAG Test Access Port

This block is the device side of a boundary-scan test port. All of its logic runs on the test clock. A host steers a sixteen-state controller with the mode-select input. The host then moves serial data through one of three registers, always one bit in and one bit out at a time: an 8-bit instruction register, a 32-bit identification register, or a one-bit bypass register. The value latched into the instruction register decides which data register sits between the serial input and the serial output.

After any reset the identification instruction is active. Because bit 0 of the identification word is always 1 and the bypass register always captures 0, the first bit shifted out tells the host which of the two it is reading. When the instruction register is captured, its two low bits hold a fixed 01 pattern. Its six upper bits hold a status value supplied by the surrounding design.

Top module: `jtag_tap`

## Requirements
- R1: On each rising test-clock edge the controller moves to its next state, chosen by the current state and the sampled mode-select value. Five consecutive rising edges with mode-select high reach the reset state from any of the sixteen states, and that reset state re-selects the identification instruction.
- R2: Driving trst_n low forces the reset state at once, without a clock edge. It also drops tdo_en at once and selects the identification instruction.
- R3: After reset, with no instruction loaded, a data-register scan returns the 32-bit identification word.
- R4: In the instruction-capture state, the instruction shift register loads {cap_status, 2'b01}. Bits 1:0 = 01 are shifted out first, least significant bit first.
- R5: The bits shifted into the instruction register are latched as the new instruction on the falling edge while the controller is in the instruction-update state.
- R6: Instruction code 8'h01 selects the identification register. Its captured value is {VERSION[3:0], PART[15:0], MFR[10:0], 1'b1}, and it is shifted out least significant bit first.
- R7: Every instruction code other than 8'h01 selects the one-bit bypass register. That register captures 0, so a data scan first returns 0 and then returns the serial input delayed by one bit.
- R8: tdo and tdo_en change only on falling test-clock edges. tdo_en is 1 only while the controller is in a shift state, and 0 in every other state, including pause.
- R9: Leaving a shift state through pause and resuming through the second exit state keeps the partly shifted contents, so the complete word still comes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data input |
| cap_status | input | IR_W-2 | Design status loaded into the upper instruction bits at capture |
| tdo | output | 1 | Serial data output, updated on the falling edge |
| tdo_en | output | 1 | Output enable for tdo, high only in the shift states |

## Verification
Each captured bit reaches tdo on the falling edge that follows entry into a shift state. Each following bit appears on the falling edge after the rising edge that shifted it. The bench therefore drives tms and tdi just after a falling edge and samples tdo and tdo_en in the same half cycle, before the rising edge that consumes the bit. A new instruction takes effect at the falling edge of the update state, which lies before the following data scan starts. The bench sweeps every instruction code and walks into each of the sixteen states before applying five high mode-select bits. Every result is compared with values built from the identification fields and from the shifted pattern.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_SEL_DR   = 4'd2,
    ST_CAP_DR   = 4'd3,
    ST_SH_DR    = 4'd4,
    ST_EX1_DR   = 4'd5,
    ST_PAU_DR   = 4'd6,
    ST_EX2_DR   = 4'd7,
    ST_UPD_DR   = 4'd8,
    ST_SEL_IR   = 4'd9,
    ST_CAP_IR   = 4'd10,
    ST_SH_IR    = 4'd11,
    ST_EX1_IR   = 4'd12,
    ST_PAU_IR   = 4'd13,
    ST_EX2_IR   = 4'd14,
    ST_UPD_IR   = 4'd15
  } tap_state_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    tap_state_t n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      default:   n = m ? ST_SEL_DR : ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int            IR_W      = 8,
  parameter logic [IR_W-1:0] RESET_OP = IR_W'(1)
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  input  logic [IR_W-3:0] cap_status,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_q
);

  logic [IR_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= {{(IR_W-2){1'b0}}, 2'b01};
    end else if (state == ST_CAP_IR) begin
      sr <= {cap_status, 2'b01};
    end else if (state == ST_SH_IR) begin
      sr <= {tdi, sr[IR_W-1:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= RESET_OP;
    else if (state == ST_RESET)  ir_q <= RESET_OP;
    else if (state == ST_UPD_IR) ir_q <= sr;
  end

  assign ir_lsb = sr[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '1
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_t state,
  input  logic       sel_id,
  output logic       dr_bit
);

  logic [ID_W-1:0] id_sr;
  logic            byp;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= '0;
      byp   <= 1'b0;
    end else if (state == ST_CAP_DR) begin
      if (sel_id) id_sr <= ID_VALUE;
      byp <= 1'b0;
    end else if (state == ST_SH_DR) begin
      if (sel_id) id_sr <= {tdi, id_sr[ID_W-1:1]};
      else        byp   <= tdi;
    end
  end

  assign dr_bit = sel_id ? id_sr[0] : byp;

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
  import jtag_tap_pkg::*;
#(
  parameter int           IR_W    = 8,
  parameter logic [3:0]   VERSION = 4'h3,
  parameter logic [15:0]  PART    = 16'hA5C7,
  parameter logic [10:0]  MFR     = 11'h2B5
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic [IR_W-3:0] cap_status,
  output logic            tdo,
  output logic            tdo_en
);

  localparam int              ID_W      = 32;
  localparam logic [ID_W-1:0] ID_VALUE  = {VERSION, PART, MFR, 1'b1};
  localparam logic [IR_W-1:0] OP_IDCODE = IR_W'(1);

  tap_state_t      state_q;
  logic            ir_lsb;
  logic [IR_W-1:0] ir_q;
  logic            sel_id;
  logic            dr_bit;
  logic            in_shift;

  tap_ctrl u_ctrl (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state_q)
  );

  tap_ir #(.IR_W(IR_W), .RESET_OP(OP_IDCODE)) u_ir (
    .tck        (tck),
    .trst_n     (trst_n),
    .tdi        (tdi),
    .state      (state_q),
    .cap_status (cap_status),
    .ir_lsb     (ir_lsb),
    .ir_q       (ir_q)
  );

  assign sel_id = (ir_q == OP_IDCODE);

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck    (tck),
    .trst_n (trst_n),
    .tdi    (tdi),
    .state  (state_q),
    .sel_id (sel_id),
    .dr_bit (dr_bit)
  );

  assign in_shift = (state_q == ST_SH_IR) || (state_q == ST_SH_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (state_q == ST_SH_IR) ? ir_lsb : dr_bit;
      tdo_en <= in_shift;
    end
  end

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic       tdo_en,
  input tap_state_t state,
  input logic       ir_lsb,
  input logic       dr_bit,
  input logic       sel_id
);

  logic [2:0] ones;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        ones <= 3'd0;
    else if (!tms)      ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones == 3'd5) |-> (state == ST_RESET));

  a_r3_reset_selects_id: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |-> sel_id);

  a_r4_ir_capture_low: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> ir_lsb);

  a_r6_id_capture_bit0: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && sel_id) |=> dr_bit);

  a_r7_bypass_capture: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && !sel_id) |=> !dr_bit);

  a_r8_enable_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind jtag_tap jtag_tap_chk u_chk (
  .tck    (tck),
  .trst_n (trst_n),
  .tms    (tms),
  .tdo_en (tdo_en),
  .state  (state_q),
  .ir_lsb (ir_lsb),
  .dr_bit (dr_bit),
  .sel_id (sel_id)
);

// File: tb/sim_jtag_tap.sv
`timescale 1ns/100ps
module sim_jtag_tap;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [5:0] cap_status = 6'd0;
  wire        tdo;
  wire        tdo_en;

  localparam logic [31:0] EXP_ID = {4'h3, 16'hA5C7, 11'h2B5, 1'b1};

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  jtag_tap u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .cap_status(cap_status), .tdo(tdo), .tdo_en(tdo_en)
  );

  always #2 tck = ~tck;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk(input logic m, input logic d, output logic o, output logic e);
    tms = m;
    tdi = d;
    o = tdo;
    e = tdo_en;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o, e, en_ok;
    en_ok = 1'b1;
    dout = '0;
    for (int i = 0; i < n; i++) begin
      clk(i == n-1, din[i], o, e);
      dout[i] = o;
      if (e !== 1'b1) en_ok = 1'b0;
    end
    check("R8 enable during shift", {63'd0, en_ok}, 64'd1);
  endtask

  task automatic finish_scan();
    logic o, e;
    clk(1'b1, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    check("R8 enable low in idle", {63'd0, tdo_en}, 64'd0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o, e;
    clk(1'b1, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    shift_bits(n, din, dout);
    finish_scan();
  endtask

  task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
    logic o, e;
    logic [63:0] dout;
    clk(1'b1, 1'b0, o, e);
    clk(1'b1, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    shift_bits(8, {56'd0, op}, dout);
    cap = dout[7:0];
    finish_scan();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  logic [6:0] pbits [16];
  int         plen  [16];

  initial begin
    logic o, e;
    logic [63:0] d;
    logic [7:0]  c;
    logic [32:0] pat;

    pbits[0]  = 7'b0000111; plen[0]  = 3;
    pbits[1]  = 7'b0000000; plen[1]  = 1;
    pbits[2]  = 7'b0000001; plen[2]  = 1;
    pbits[3]  = 7'b0000001; plen[3]  = 2;
    pbits[4]  = 7'b0000001; plen[4]  = 3;
    pbits[5]  = 7'b0001001; plen[5]  = 4;
    pbits[6]  = 7'b0001001; plen[6]  = 5;
    pbits[7]  = 7'b0101001; plen[7]  = 6;
    pbits[8]  = 7'b0011001; plen[8]  = 5;
    pbits[9]  = 7'b0000011; plen[9]  = 2;
    pbits[10] = 7'b0000011; plen[10] = 3;
    pbits[11] = 7'b0000011; plen[11] = 4;
    pbits[12] = 7'b0010011; plen[12] = 5;
    pbits[13] = 7'b0010011; plen[13] = 6;
    pbits[14] = 7'b1010011; plen[14] = 7;
    pbits[15] = 7'b0110011; plen[15] = 6;

    @(negedge tck);
    #1;
    check("R2 enable low in reset", {63'd0, tdo_en}, 64'd0);
    trst_n = 1'b1;
    clk(1'b0, 1'b0, o, e);

    // R3: identification word available straight after reset
    scan_dr(32, 64'd0, d);
    check("R3 id after reset", d[31:0], EXP_ID);

    // R4 R5 R6 R7: every instruction code
    for (int op = 0; op < 256; op++) begin
      cap_status = 6'(op) ^ 6'h2A;
      scan_ir(8'(op), c);
      check("R4 ir capture", c, {cap_status, 2'b01});
      pat = {8'(op) ^ 8'h5C, 8'(op), ~8'(op), 8'(op) + 8'h33, 1'b1};
      scan_dr(33, {31'd0, pat}, d);
      if (op == 1) check("R6 idcode select", d[31:0], EXP_ID);
      else         check("R7 bypass delay", d[32:0], {pat[31:0], 1'b0});
    end

    // R9: pause in mid-scan of the identification register
    scan_ir(8'h01, c);
    clk(1'b1, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    shift_bits(16, 64'd0, d);
    clk(1'b0, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    check("R8 enable low in pause", {63'd0, tdo_en}, 64'd0);
    clk(1'b1, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    begin
      logic [63:0] d2;
      shift_bits(16, 64'd0, d2);
      check("R9 pause resume", {d2[15:0], d[15:0]}, EXP_ID);
    end
    finish_scan();

    // R1: five high mode-select bits from every state
    for (int s = 0; s < 16; s++) begin
      scan_ir(8'hFF, c);
      for (int k = 0; k < plen[s]; k++) clk(pbits[s][k], 1'b1, o, e);
      for (int k = 0; k < 5; k++) clk(1'b1, 1'b1, o, e);
      clk(1'b0, 1'b0, o, e);
      scan_dr(33, 64'h1_2345_6789, d);
      check($sformatf("R1 reset from state %0d", s), d[31:0], EXP_ID);
    end

    // R5: loaded instruction stays until next update
    scan_ir(8'h80, c);
    scan_dr(9, 64'h1A5, d);
    check("R5 instruction latched", d[8:0], {8'hA5, 1'b0});

    // R2: asynchronous reset during a bypass shift
    scan_ir(8'hFF, c);
    clk(1'b1, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    clk(1'b0, 1'b0, o, e);
    check("R2 enable before trst", {63'd0, tdo_en}, 64'd1);
    trst_n = 1'b0;
    #0.5;
    check("R2 enable drops at once", {63'd0, tdo_en}, 64'd0);
    @(negedge tck);
    #1;
    trst_n = 1'b1;
    clk(1'b0, 1'b0, o, e);
    scan_dr(32, 64'd0, d);
    check("R2 id after trst", d[31:0], EXP_ID);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

endmodule